// File: doc/BRIEF.md
# PCI Slot Hotplug Controller

This block is the register bank through which firmware learns about PCI slot hotplug activity and asks for devices to be removed. It serves up to 32 slots. The platform side sends one-cycle pulses when a device is inserted into a slot or when removal of a slot's device is requested. The block latches each event into a pending mask, one mask for insertions and one for removals. While either mask holds a set bit, it holds a level output high. That level feeds general-purpose-event bit 1, which in turn raises the SCI interrupt.

Firmware reads both pending masks in its event handler. It ejects a device by writing that slot's bit to the eject word. The eject write clears the slot's pending bits. The block also reports the ejected slots back to the platform as a mask that lasts one cycle. A fourth word reports which slots are removable; that mask comes from a configuration input. Reading the eject word returns a feature word, and no feature bits are defined.

The register bus is 32 bits wide and uses 4-byte, word-aligned addresses. Read data is combinational from the address.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: Byte offset 0x0 reads the insert-pending mask, one bit per slot (bit n = slot n). A pulse on `insertPulse[n]` sets bit n at the next clock edge.
- R2: Byte offset 0x4 reads the removal-pending mask. A pulse on `removeReq[n]` sets bit n at the next edge only if `removableCfg[n]` is 1. Otherwise the pulse is dropped.
- R3: Byte offset 0xC reads the removable mask, which always equals `removableCfg`.
- R4: A read of byte offset 0x8 returns the feature word, which is all zeros.
- R5: A write to byte offset 0x8 clears, at that clock edge, the insert-pending and removal-pending bits of every slot whose data bit is 1. Other slots keep their bits.
- R6: In the cycle after a write to offset 0x8, `ejectMask` equals the written data limited to the implemented slots. In every other cycle it is zero.
- R7: An insert pulse or an accepted removal request in the same cycle as an eject of the same slot wins: that pending bit ends up set.
- R8: `gpeLevel` is 1 exactly when the insert-pending mask or the removal-pending mask is non-zero.
- R9: Writes to offsets 0x0, 0x4 and 0xC have no effect on any state or output. Accesses whose two low address bits are not zero do nothing on writes and read as zero.
- R10: While `rst_n` is low, both pending masks are cleared, and `gpeLevel` and `ejectMask` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insertPulse | input | NUM_SLOTS | One-cycle insert event per slot |
| removeReq | input | NUM_SLOTS | One-cycle removal request per slot |
| removableCfg | input | NUM_SLOTS | Per-slot removable configuration |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr (combinational) |
| ejectMask | output | NUM_SLOTS | One-cycle mask of ejected slots |
| gpeLevel | output | 1 | Event level for GPE bit 1 |

## Verification
A pending bit that is wrongly set or lost shows up two ways. The read at offset 0x0 or 0x4 returns the wrong mask in the cycle after the event edge. `gpeLevel` then stays high or falls early from that same cycle. A wrong eject path shows up one cycle after the write: either `ejectMask` carries the wrong bits or stays non-zero past one cycle, or the pending bits that should be cleared still read back. A bad address decode shows up at once, because a write to a read-only word changes one of the masks read in the next cycle.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    SEL_UP   = 2'd0,
    SEL_DOWN = 2'd1,
    SEL_FEAT = 2'd2,
    SEL_RMV  = 2'd3
  } hp_sel_e;

  typedef struct packed {
    logic    wrEject;
    logic    rdValid;
    hp_sel_e rdSel;
  } hp_strobe_t;
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output hp_strobe_t        stb
);
  localparam int WORD_LSB = 2;

  logic aligned;
  logic inRange;
  hp_sel_e sel;

  assign aligned = (busAddr[WORD_LSB-1:0] == '0);
  assign inRange = ((busAddr >> WORD_LSB) < 4);
  assign sel     = hp_sel_e'(busAddr[WORD_LSB +: 2]);

  always_comb begin
    stb         = '0;
    stb.rdSel   = sel;
    stb.rdValid = aligned && inRange;
    stb.wrEject = busWrEn && aligned && inRange && (sel == SEL_FEAT);
  end

  // R9
  wr_only_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrEject |-> (busWrEn && busAddr == ADDR_W'(8)));
endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] FEATURE_WORD = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hp_strobe_t           stb,
  input  logic [NUM_SLOTS-1:0] insertPulse,
  input  logic [NUM_SLOTS-1:0] removeReq,
  input  logic [NUM_SLOTS-1:0] removableCfg,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_SLOTS-1:0] ejectMask,
  output logic                 gpeLevel
);
  logic [NUM_SLOTS-1:0] upQ, downQ, ejectQ;
  logic [NUM_SLOTS-1:0] ejectBits, acceptRemove;

  assign ejectBits    = stb.wrEject ? busWrData[NUM_SLOTS-1:0] : '0;
  assign acceptRemove = removeReq & removableCfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upQ    <= '0;
      downQ  <= '0;
      ejectQ <= '0;
    end else begin
      upQ    <= (upQ & ~ejectBits) | insertPulse;
      downQ  <= (downQ & ~ejectBits) | acceptRemove;
      ejectQ <= ejectBits;
    end
  end

  assign ejectMask = ejectQ;
  assign gpeLevel  = (|upQ) | (|downQ);

  always_comb begin
    busRdData = '0;
    if (stb.rdValid) begin
      unique case (stb.rdSel)
        SEL_UP:   busRdData = DATA_W'(upQ);
        SEL_DOWN: busRdData = DATA_W'(downQ);
        SEL_FEAT: busRdData = FEATURE_WORD;
        SEL_RMV:  busRdData = DATA_W'(removableCfg);
      endcase
    end
  end

  // R6
  eject_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrEject |=> (ejectMask == '0));

  // R2
  down_needs_removable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((downQ & ~$past(downQ) & ~$past(removableCfg)) == '0));

  // R5
  eject_clears_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrEject |=> ((upQ & $past(busWrData[NUM_SLOTS-1:0]) & ~$past(insertPulse)) == '0));

  // R8
  gpe_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpeLevel) |-> $past((|insertPulse) || (|acceptRemove)));

  // R1
  up_set_by_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((upQ & ~$past(upQ) & ~$past(insertPulse)) == '0));
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] insertPulse,
  input  logic [NUM_SLOTS-1:0] removeReq,
  input  logic [NUM_SLOTS-1:0] removableCfg,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_SLOTS-1:0] ejectMask,
  output logic                 gpeLevel
);
  hp_strobe_t stb;

  hp_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  hp_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .insertPulse  (insertPulse),
    .removeReq    (removeReq),
    .removableCfg (removableCfg),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .ejectMask    (ejectMask),
    .gpeLevel     (gpeLevel)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!gpeLevel && ejectMask == '0));
endmodule

// File: tb/slot_hotplug_ctrl_tb.sv
module slot_hotplug_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insertPulse = '0, removeReq = '0, removableCfg = 32'h0000_FFFF;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData, ejectMask;
  logic        gpeLevel;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  slot_hotplug_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .insertPulse(insertPulse), .removeReq(removeReq),
    .removableCfg(removableCfg), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ejectMask(ejectMask),
    .gpeLevel(gpeLevel)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] rem;
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expUp;
    logic [31:0] expDown;
    logic [31:0] expEj;
    logic        expGpe;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h5, 32'h0, 1'b0, 4'h0, 32'h0, 32'h5, 32'h0, 32'h0, 1'b1},
    '{32'h0, 32'h0001_0003, 1'b0, 4'h0, 32'h0, 32'h5, 32'h3, 32'h0, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'h8, 32'h1, 32'h4, 32'h2, 32'h1, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'h0, 32'hFFFF_FFFF, 32'h4, 32'h2, 32'h0, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'h4, 32'hFFFF_FFFF, 32'h4, 32'h2, 32'h0, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'hC, 32'h0, 32'h4, 32'h2, 32'h0, 1'b1},
    '{32'h4, 32'h0, 1'b1, 4'h8, 32'h6, 32'h4, 32'h0, 32'h6, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'h8, 32'h4, 32'h0, 32'h0, 32'h4, 1'b0},
    '{32'h8000_0000, 32'h0000_8000, 1'b0, 4'h0, 32'h0, 32'h8000_0000, 32'h8000, 32'h0, 1'b1},
    '{32'h0, 32'h0, 1'b1, 4'h8, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check("R10 gpe", {31'b0, gpeLevel}, 32'h0);
    check("R10 eject", ejectMask, 32'h0);
    readReg(4'h0, rd); check("R10 up", rd, 32'h0);
    readReg(4'h4, rd); check("R10 down", rd, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 feature word, R3 removable read
    readReg(4'h8, rd); check("R4 feature", rd, 32'h0);
    readReg(4'hC, rd); check("R3 removable", rd, 32'h0000_FFFF);

    // Vector walk: R1 R2 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      insertPulse = VECS[i].ins;
      removeReq   = VECS[i].rem;
      busWrEn     = VECS[i].wr;
      busAddr     = VECS[i].addr;
      busWrData   = VECS[i].wdata;
      @(posedge clk);
      #1;
      insertPulse = '0; removeReq = '0; busWrEn = 1'b0;
      check($sformatf("R6 eject v%0d", i), ejectMask, VECS[i].expEj);
      readReg(4'h0, rd); check($sformatf("R1 up v%0d", i), rd, VECS[i].expUp);
      readReg(4'h4, rd); check($sformatf("R2 down v%0d", i), rd, VECS[i].expDown);
      check($sformatf("R8 gpe v%0d", i), {31'b0, gpeLevel}, {31'b0, VECS[i].expGpe});
      if (i == 5) begin
        readReg(4'hC, rd); check("R9 removable unchanged", rd, 32'h0000_FFFF);
      end
      @(posedge clk);
      #1;
      check($sformatf("R6 eject drop v%0d", i), ejectMask, 32'h0);
    end

    // R3: removable follows config input
    removableCfg = 32'hA5A5_0000;
    readReg(4'hC, rd); check("R3 removable cfg", rd, 32'hA5A5_0000);

    // R9: misaligned write ignored, misaligned read zero
    @(negedge clk);
    insertPulse = 32'h10;
    @(posedge clk); #1; insertPulse = '0;
    @(negedge clk);
    busAddr = 4'h9; busWrData = 32'hFFFF_FFFF; busWrEn = 1'b1;
    @(posedge clk); #1; busWrEn = 1'b0;
    check("R9 misaligned no eject", ejectMask, 32'h0);
    readReg(4'h0, rd); check("R9 misaligned up kept", rd, 32'h10);
    readReg(4'h1, rd); check("R9 misaligned read zero", rd, 32'h0);

    // R10: mid-run reset clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    readReg(4'h0, rd); check("R10 up cleared", rd, 32'h0);
    check("R10 gpe cleared", {31'b0, gpeLevel}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule